// File: doc/BRIEF.md
# Phase Accumulator Core with Gated Offset and Quadrant Shift

This block is the phase engine of a numerically controlled oscillator. On every rising edge of the core clock it advances a 48-bit phase accumulator by a tuning step. The step is the sum of a center frequency word and an offset frequency word. A single enable input passes the offset word into that sum, or replaces it with zero. Gating only selects what goes into the sum. The offset word itself is never changed.

After the accumulator, a 2-bit quadrant select rotates the phase by a multiple of a quarter turn. The rotated phase is cut down to its 14 most significant bits and registered. The result is the phase word that a later sine lookup would read. Because the shift is applied after the accumulator, changing the quadrant moves the output at once and leaves the running phase as it was.

An active-low asynchronous reset clears both the accumulator and the output register, so the phase restarts from zero.

Top module: `nco_phase_core`

## Requirements
- R1: While rst_ni is low, phase_o reads 0 and the accumulator holds 0. After release, a zero tuning step keeps phase_o at 0.
- R2: At each rising clock edge, the accumulator adds the tuning step modulo 2^48. With a zero step it holds its value.
- R3: When offset_en_i is 1, the tuning step is center_word_i + offset_word_i.
- R4: When offset_en_i is 0, the tuning step is center_word_i alone. Gating leaves the offset word untouched, so raising offset_en_i again restores the same per-cycle advance as before.
- R5: The sum of the center and offset words wraps modulo 2^48. For example, all-ones plus 2 gives a step of 1.
- R6: quad_sel_i adds its value into accumulator bits [47:46] modulo 2^48. The codes are 2'b00 = 0°, 2'b01 = 90°, 2'b10 = 180° and 2'b11 = 270°.
- R7: phase_o equals bits [47:34] of the shifted phase, registered. It shows the accumulator value from before the current edge, which makes it one cycle behind the accumulator.
- R8: A change of quad_sel_i alters phase_o one edge later and does not disturb the accumulated phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| center_word_i | input | 48 | Center frequency tuning word |
| offset_word_i | input | 48 | Offset frequency tuning word |
| offset_en_i | input | 1 | 1 passes the offset word into the step, 0 passes zero |
| quad_sel_i | input | 2 | Quadrant phase shift select |
| phase_o | output | 14 | Registered upper phase bits |

## Verification
The bench targets several corner cases, each of which exposes a specific fault:
- An all-ones center word plus a small offset makes the step wrap to one. A design that widens or saturates the sum would race ahead or stick.
- Toggling the offset enable while the center word is zero shows whether gating truly adds zero, and whether the old advance returns on re-enable.
- Each quadrant code is applied on a frozen accumulator. A swapped code or a shift into the wrong bits shows up as a wrong top-bit pattern.
- A reset in mid-run and a one-LSB-per-cycle step expose a missing output register or an accumulator that fails to restart from zero.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned ACC_W  = 48;
  localparam int unsigned OUT_W  = 14;
  localparam int unsigned QUAD_W = 2;
  typedef logic [ACC_W-1:0]  acc_t;
  typedef logic [OUT_W-1:0]  out_t;
  typedef logic [QUAD_W-1:0] quad_t;
endpackage

// File: rtl/nco_tuning_sum.sv
module nco_tuning_sum #(
  parameter int unsigned ACC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] center_i,
  input  logic [ACC_W-1:0] offset_i,
  input  logic             offset_en_i,
  output logic [ACC_W-1:0] step_o
);
  logic [ACC_W-1:0] offset_gated;

  assign offset_gated = offset_en_i ? offset_i : '0;
  assign step_o       = center_i + offset_gated;  // wraps mod 2^ACC_W

  AST_OFF_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !offset_en_i |-> (step_o == center_i)); // R4
  AST_OFF_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offset_en_i |-> ((step_o - offset_i) == center_i)); // R3
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned ACC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] step_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + step_i;
  end

  assign acc_o = acc_q;

  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == '0) |=> $stable(acc_q)); // R2
endmodule

// File: rtl/nco_quad_shift.sv
module nco_quad_shift #(
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned OUT_W  = 14,
  parameter int unsigned QUAD_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [QUAD_W-1:0] quad_i,
  output logic [OUT_W-1:0]  phase_o
);
  localparam int unsigned LOW_W = ACC_W - QUAD_W;

  logic [ACC_W-1:0] shifted;
  logic [OUT_W-1:0] phase_q;

  // quadrant code lands in the top bits; carry out drops (mod 2^ACC_W)
  assign shifted = acc_i + {quad_i, {LOW_W{1'b0}}};

  generate
    if (OUT_W < ACC_W) begin : g_trunc
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) phase_q <= '0;
        else         phase_q <= shifted[ACC_W-1 -: OUT_W];
      end
    end else begin : g_full
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) phase_q <= '0;
        else         phase_q <= shifted[OUT_W-1:0];
      end
    end
  endgenerate

  assign phase_o = phase_q;

  AST_QUAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_i == '0) |=> (phase_o == $past(acc_i[ACC_W-1 -: OUT_W]))); // R6
  AST_QUAD_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_i == QUAD_W'(2)) |=>
      (phase_o == ($past(acc_i[ACC_W-1 -: OUT_W]) ^ {1'b1, {(OUT_W-1){1'b0}}}))); // R6
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
  import nco_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ACC_W-1:0]  center_word_i,
  input  logic [ACC_W-1:0]  offset_word_i,
  input  logic              offset_en_i,
  input  logic [QUAD_W-1:0] quad_sel_i,
  output logic [OUT_W-1:0]  phase_o
);
  acc_t step;
  acc_t acc;

  nco_tuning_sum #(.ACC_W(ACC_W)) u_sum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .center_i    (center_word_i),
    .offset_i    (offset_word_i),
    .offset_en_i (offset_en_i),
    .step_o      (step)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .acc_o  (acc)
  );

  nco_quad_shift #(.ACC_W(ACC_W), .OUT_W(OUT_W), .QUAD_W(QUAD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc),
    .quad_i  (quad_sel_i),
    .phase_o (phase_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((center_word_i == '0) && !offset_en_i) |=> $stable(acc)); // R1
endmodule

// File: tb/tb_nco_phase_core.sv
module tb_nco_phase_core;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W = 48;
  localparam int OUT_W = 14;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [ACC_W-1:0] center_word = '0;
  logic [ACC_W-1:0] offset_word = '0;
  logic             offset_en = 1'b0;
  logic [1:0]       quad_sel = 2'b00;
  logic [OUT_W-1:0] phase;

  int n_tests = 0;
  int n_fail  = 0;
  logic [ACC_W-1:0] m_acc = '0;
  logic [OUT_W-1:0] m_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nco_phase_core dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .center_word_i (center_word),
    .offset_word_i (offset_word),
    .offset_en_i   (offset_en),
    .quad_sel_i    (quad_sel),
    .phase_o       (phase)
  );

  function automatic logic [ACC_W-1:0] ref_step(logic [ACC_W-1:0] c, logic [ACC_W-1:0] o, logic en);
    return c + (en ? o : '0);
  endfunction

  function automatic logic [OUT_W-1:0] ref_phase(logic [ACC_W-1:0] a, logic [1:0] q);
    logic [ACC_W-1:0] s;
    s = a + {q, {(ACC_W-2){1'b0}}};
    return s[ACC_W-1 -: OUT_W];
  endfunction

  task automatic check(string req, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: phase_o=%h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, model the edge, compare at the following negedge
  task automatic step(logic [ACC_W-1:0] c, logic [ACC_W-1:0] o, logic en, logic [1:0] q);
    center_word = c; offset_word = o; offset_en = en; quad_sel = q;
    @(posedge clk);
    m_out = ref_phase(m_acc, q);
    m_acc = m_acc + ref_step(c, o, en);
    @(negedge clk);
  endtask

  localparam logic [ACC_W-1:0] LSB = 48'h1 << (ACC_W - OUT_W);

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", phase, '0);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step('0, 48'h1234, 1'b0, 2'b00);
      check("R1 idle after reset", phase, '0);
    end
    // one LSB per cycle: output lags accumulator by one
    step(LSB, '0, 1'b0, 2'b00);
    check("R7 lag first edge", phase, 14'd0);
    step(LSB, '0, 1'b0, 2'b00);
    check("R7 one lsb", phase, 14'd1);
    step(LSB, '0, 1'b0, 2'b00);
    check("R2 two lsb", phase, 14'd2);
    // offset gating with center zero
    step('0, LSB, 1'b1, 2'b00);
    check("R3 offset on", phase, m_out);
    step('0, LSB, 1'b1, 2'b00);
    check("R3 offset adds", phase, 14'd4);
    step('0, LSB, 1'b0, 2'b00);
    check("R4 gated", phase, 14'd5);
    step('0, LSB, 1'b0, 2'b00);
    check("R4 gated hold", phase, 14'd5);
    step('0, LSB, 1'b1, 2'b00);
    check("R4 reenable", phase, 14'd5);
    step('0, LSB, 1'b1, 2'b00);
    check("R4 offset restored", phase, 14'd6);
    // wrap of center+offset: step of 1 below output resolution
    for (int i = 0; i < 3; i++) begin
      step({ACC_W{1'b1}}, 48'd2, 1'b1, 2'b00);
      check("R5 sum wrap", phase, m_out);
    end
    step({ACC_W{1'b1}} - LSB + 48'd1, LSB, 1'b1, 2'b00);
    check("R5 wrap exact", phase, m_out);
    // quadrant codes on a frozen accumulator
    for (int q = 0; q < 4; q++) begin
      step('0, '0, 1'b0, 2'(q));
      step('0, '0, 1'b0, 2'(q));
      check($sformatf("R6 quad %0d", q), phase, ref_phase(m_acc, 2'(q)));
    end
    step('0, '0, 1'b0, 2'b00);
    check("R8 quad back to 0", phase, m_out);
    // quad change under running accumulator
    for (int i = 0; i < 8; i++) begin
      step(48'h0123_4567_89AB, '0, 1'b0, 2'(i));
      check("R8 running quad", phase, m_out);
    end
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [ACC_W-1:0] c, o;
      c = {$urandom(), $urandom()};
      o = {$urandom(), $urandom()};
      if (i % 7 == 0) c = {ACC_W{1'b1}};
      step(c, o, 1'($urandom() & 1), 2'($urandom()));
      check("R2 random", phase, m_out);
    end
    // mid-run reset
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", phase, '0);
    m_acc = '0; m_out = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    step('0, '0, 1'b0, 2'b00);
    check("R1 restart", phase, '0);
    step(LSB, '0, 1'b0, 2'b00);
    step(LSB, '0, 1'b0, 2'b00);
    check("R1 restart from zero", phase, 14'd1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule